// File: doc/BRIEF.md
# Dual-Port Parallel I/O Register File

This block is the processor-facing register file of a parallel interface adapter. It has two 8-bit bidirectional ports, A and B. Each side holds a 6-bit configuration field and two interrupt flags, which together form its control register. Each side also holds a direction register and an output register. A two-bit register select and a chip select pick one register per access. A routing bit in each side's control register decides whether the shared port address reaches the direction register or the output register.

A write is captured in a holding stage on the first bus-clock edge. It is committed to its target on the following edge. The target is decoded at commit time, so a control-register write followed at once by a port write uses the new routing bit. The two sides read back differently. Port A returns the pin levels on every line. Port B returns its output register on output lines and the pin levels on input lines. A read of a side's data register clears that side's flags. A read of port A data raises a one-cycle strobe, and a committed write to port B data raises a one-cycle strobe. Both strobes go to the control-line logic, which lives outside this block and feeds the flags through set pulses.

Top module: `pio_regfile`

## Requirements
- R1: A synchronous active-low reset clears all six registers: every direction enable is 0, every output register is 0, and both control registers read 0x00.
- R2: Register select 2'b00 addresses side A's port address, 2'b01 side A's control register, 2'b10 side B's port address and 2'b11 side B's control register. An access takes place only while cs is 1.
- R3: Control-register bit 2 routes the port address for both reads and writes: 0 reaches the direction register and 1 reaches the output register.
- R4: Each direction bit drives the output enable of its line (1 is output, 0 is input). Each output-register bit drives that line's output value.
- R5: A read of port A data (bit 2 = 1) returns pa_in on all 8 lines, whatever the direction bits are.
- R6: A read of port B data (bit 2 = 1) returns, per line, the output-register bit where the direction bit is 1 and pb_in where it is 0.
- R7: A write presented in a cycle is captured at the next rising edge and becomes visible at the edge after that. The port-address route is taken from bit 2 as it stands at the commit edge.
- R8: Control bits 7 and 6 ignore writes. Flag-set input bit 1 sets bit 7 and bit 0 sets bit 6. A read of that side's port address with bit 2 = 1 clears both bits. A direction-register read does not clear them. A set in the same cycle as a clear wins.
- R9: a_rd_stb is 1 for exactly the cycle after each cycle that reads port A data (sel 00, bit 2 = 1). It stays 0 for direction-register reads and for side B reads.
- R10: b_wr_stb is 1 in the cycle after a write commits to port B's output register. It stays 0 for direction-register writes and for side A writes.
- R11: rdata is 0x00 unless cs and rd are both 1. A write strobe with cs at 0 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read access in this cycle |
| wr | input | 1 | Write access in this cycle |
| sel | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output values |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output values |
| pb_oe | output | 8 | Port B output enables |
| a_flag_set | input | 2 | Side A flag set pulses (bit 1 to bit 7, bit 0 to bit 6) |
| b_flag_set | input | 2 | Side B flag set pulses |
| a_cfg | output | 6 | Side A control bits 5..0 |
| b_cfg | output | 6 | Side B control bits 5..0 |
| a_rd_stb | output | 1 | Port A data-read strobe |
| b_wr_stb | output | 1 | Port B data-write strobe |

## Verification
Most internal errors show up at the ports one commit later. A wrong route bit or a mis-decoded commit puts data on pa_oe or pb_oe instead of pa_out or pb_out, and this is visible two edges after the write is presented. Flag state that is cleared or kept wrongly shows on the next control-register read. A strobe that fires or is missed shows in the single cycle that follows the access.

// File: rtl/pio_pkg.sv
// Package: shared widths, register-select codes and the pending-write record.
// Assumes an 8-bit control register layout: [7:6] flags, [5:0] configuration.
package pio_pkg;
    localparam int unsigned PIO_W     = 8;
    localparam int unsigned CFG_W     = 6;
    localparam int unsigned FLAG_W    = 2;
    localparam int unsigned ROUTE_BIT = 2;

    typedef enum logic [1:0] {
        SEL_A_PORT = 2'b00,
        SEL_A_CTRL = 2'b01,
        SEL_B_PORT = 2'b10,
        SEL_B_CTRL = 2'b11
    } pio_sel_e;

    typedef struct packed {
        logic             valid;
        logic [1:0]       sel;
        logic [PIO_W-1:0] data;
    } pio_wr_t;
endpackage

// File: rtl/pio_wr_latch.sv
// Write holding stage: captures a selected write on the bus-clock edge so
// that the register update happens one edge later.
// Assumes cs/wr/sel/wdata are stable around the capturing edge.
module pio_wr_latch
    import pio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs,
    input  logic             wr,
    input  logic [1:0]       sel,
    input  logic [PIO_W-1:0] wdata,
    output pio_wr_t          pend
);
    // Capture one pending write per access cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            pend.valid <= cs && wr;
            if (cs && wr) begin
                pend.sel  <= sel;
                pend.data <= wdata;
            end
        end
    end

    a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr) |=> pend.valid);
    a_r11_no_cs_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs) |=> !pend.valid);
endmodule

// File: rtl/pio_side.sv
// One port side: configuration, flags, direction and output registers,
// plus the port readback view. PIN_READBACK=1 returns raw pins on every
// line, 0 returns the output register on output lines.
// Assumes commit_* come from the write holding stage and rd_port is a
// qualified data-register read of this side.
module pio_side
    import pio_pkg::*;
#(
    parameter int unsigned W            = PIO_W,
    parameter bit          PIN_READBACK = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic              commit_ctrl,
    input  logic [W-1:0]      commit_data,
    input  logic              rd_port,
    input  logic [FLAG_W-1:0] flag_set,
    input  logic [W-1:0]      pin_in,
    output logic [7:0]        cr,
    output logic [W-1:0]      ddr,
    output logic [W-1:0]      outr,
    output logic [W-1:0]      port_view
);
    logic [CFG_W-1:0]  cfg_q;
    logic [FLAG_W-1:0] flag_q;
    logic              route_out;

    assign route_out = cfg_q[ROUTE_BIT];
    assign cr        = {flag_q, cfg_q};

    // Configuration bits take committed control writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (commit && commit_ctrl)
            cfg_q <= commit_data[CFG_W-1:0];
    end

    // Port-address writes go to direction or output register per the route bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ddr  <= '0;
            outr <= '0;
        end else if (commit && !commit_ctrl) begin
            if (route_out)
                outr <= commit_data;
            else
                ddr <= commit_data;
        end
    end

    // Flags: set pulses win over the data-read clear; writes never touch them.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= '0;
        else
            flag_q <= flag_set | (rd_port ? '0 : flag_q);
    end

    // Readback view chosen by side variant.
    generate
        if (PIN_READBACK) begin : g_pin_view
            assign port_view = pin_in;
        end else begin : g_mix_view
            assign port_view = (ddr & outr) | (~ddr & pin_in);
        end
    endgenerate

    a_r1_reset_clear: assert property (@(posedge clk)
        (!rst_n) |=> (cr == 8'h00 && ddr == '0 && outr == '0));
    a_r8_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_port && flag_set == '0) |=> $stable(flag_q));
    a_r8_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_port && flag_set == '0) |=> (flag_q == '0));
    a_r3_route_ddr: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !commit_ctrl && !route_out) |=> $stable(outr));
endmodule

// File: rtl/pio_regfile.sv
// Top: dual-port parallel I/O register file. Decodes register select,
// routes committed writes to the two sides, muxes read data and produces
// the port-A read strobe and port-B write strobe for control-line logic.
// Assumes a single synchronous bus clock and at most one access per cycle.
module pio_regfile
    import pio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              rd,
    input  logic              wr,
    input  logic [1:0]        sel,
    input  logic [PIO_W-1:0]  wdata,
    output logic [PIO_W-1:0]  rdata,
    input  logic [PIO_W-1:0]  pa_in,
    output logic [PIO_W-1:0]  pa_out,
    output logic [PIO_W-1:0]  pa_oe,
    input  logic [PIO_W-1:0]  pb_in,
    output logic [PIO_W-1:0]  pb_out,
    output logic [PIO_W-1:0]  pb_oe,
    input  logic [FLAG_W-1:0] a_flag_set,
    input  logic [FLAG_W-1:0] b_flag_set,
    output logic [CFG_W-1:0]  a_cfg,
    output logic [CFG_W-1:0]  b_cfg,
    output logic              a_rd_stb,
    output logic              b_wr_stb
);
    localparam int unsigned NSIDE = 2;

    pio_wr_t          pend;
    logic [7:0]       cr_q   [NSIDE];
    logic [PIO_W-1:0] ddr_q  [NSIDE];
    logic [PIO_W-1:0] out_q  [NSIDE];
    logic [PIO_W-1:0] view_q [NSIDE];
    logic [NSIDE-1:0] rd_port;
    logic             rd_acc;

    assign rd_acc = cs && rd;

    pio_wr_latch u_wr_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .cs    (cs),
        .wr    (wr),
        .sel   (sel),
        .wdata (wdata),
        .pend  (pend)
    );

    generate
        for (genvar s = 0; s < NSIDE; s++) begin : g_side
            // Data-register read of this side (route bit set).
            assign rd_port[s] = rd_acc && (sel[1] == 1'(s)) && !sel[0]
                                && cr_q[s][ROUTE_BIT];

            pio_side #(
                .W            (PIO_W),
                .PIN_READBACK (s == 0)
            ) u_side (
                .clk         (clk),
                .rst_n       (rst_n),
                .commit      (pend.valid && (pend.sel[1] == 1'(s))),
                .commit_ctrl (pend.sel[0]),
                .commit_data (pend.data),
                .rd_port     (rd_port[s]),
                .flag_set    ((s == 0) ? a_flag_set : b_flag_set),
                .pin_in      ((s == 0) ? pa_in : pb_in),
                .cr          (cr_q[s]),
                .ddr         (ddr_q[s]),
                .outr        (out_q[s]),
                .port_view   (view_q[s])
            );
        end
    endgenerate

    assign pa_out = out_q[0];
    assign pa_oe  = ddr_q[0];
    assign pb_out = out_q[1];
    assign pb_oe  = ddr_q[1];
    assign a_cfg  = cr_q[0][CFG_W-1:0];
    assign b_cfg  = cr_q[1][CFG_W-1:0];

    // Read-data mux; quiet when no read access.
    always_comb begin
        rdata = '0;
        if (rd_acc) begin
            case (pio_sel_e'(sel))
                SEL_A_PORT: rdata = cr_q[0][ROUTE_BIT] ? view_q[0] : ddr_q[0];
                SEL_A_CTRL: rdata = cr_q[0];
                SEL_B_PORT: rdata = cr_q[1][ROUTE_BIT] ? view_q[1] : ddr_q[1];
                default:    rdata = cr_q[1];
            endcase
        end
    end

    // Strobes toward control-line logic, one cycle per qualifying access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_rd_stb <= 1'b0;
            b_wr_stb <= 1'b0;
        end else begin
            a_rd_stb <= rd_port[0];
            b_wr_stb <= pend.valid && (pend.sel == SEL_B_PORT) && cr_q[1][ROUTE_BIT];
        end
    end

    a_r9_rd_stb_on: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd && sel == 2'b00 && a_cfg[ROUTE_BIT]) |=> a_rd_stb);
    a_r9_rd_stb_off: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && rd && sel == 2'b00 && a_cfg[ROUTE_BIT]) |=> !a_rd_stb);
    a_r10_wr_stb_src: assert property (@(posedge clk) disable iff (!rst_n)
        (pend.valid && pend.sel == 2'b10 && b_cfg[ROUTE_BIT]) |=> b_wr_stb);
    a_r11_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && rd) |-> (rdata == '0));
endmodule

// File: tb/pio_regfile_bench.sv
`timescale 1ns/1ps
module pio_regfile_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [1:0] sel = 2'b00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe;
    logic [1:0] a_flag_set = 2'b00, b_flag_set = 2'b00;
    logic [5:0] a_cfg, b_cfg;
    logic       a_rd_stb, b_wr_stb;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pio_regfile u_pio_regfile (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .sel(sel),
        .wdata(wdata), .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out),
        .pa_oe(pa_oe), .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .a_flag_set(a_flag_set), .b_flag_set(b_flag_set),
        .a_cfg(a_cfg), .b_cfg(b_cfg), .a_rd_stb(a_rd_stb), .b_wr_stb(b_wr_stb)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic wr_reg(input logic [1:0] s, input logic [7:0] d);
        cs = 1; wr = 1; sel = s; wdata = d;
        @(posedge clk); @(negedge clk);
        cs = 0; wr = 0;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic rd_reg(input logic [1:0] s, output logic [7:0] d);
        cs = 1; rd = 1; sel = s;
        #1 d = rdata;
        @(posedge clk); @(negedge clk);
        cs = 0; rd = 0;
    endtask

    task automatic flag_pulse(input logic [1:0] a, input logic [1:0] b);
        a_flag_set = a; b_flag_set = b;
        @(posedge clk); @(negedge clk);
        a_flag_set = 0; b_flag_set = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        logic [7:0] exp_b;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1: reset state
        chk("R1 pa_oe", pa_oe, 8'h00);
        chk("R1 pb_oe", pb_oe, 8'h00);
        chk("R1 pa_out", pa_out, 8'h00);
        rd_reg(2'b01, r); chk("R1 CRA", r, 8'h00);
        rd_reg(2'b11, r); chk("R1 CRB", r, 8'h00);

        // R11: quiet read bus and write without chip select
        cs = 1; sel = 2'b01; #1 chk("R11 rdata idle", rdata, 8'h00);
        cs = 0; wr = 1; sel = 2'b00; wdata = 8'hFF;
        @(posedge clk); @(negedge clk); wr = 0;
        @(posedge clk); @(negedge clk);
        chk("R11 no-cs write", pa_oe, 8'h00);

        // R2/R3/R4: DDRA sweep while route bit is 0
        for (int v = 0; v < 256; v++) begin
            wr_reg(2'b00, 8'(v));
            chk("R4 pa_oe", pa_oe, 8'(v));
            chk("R10 no stb on ddra", {7'b0, b_wr_stb}, 8'h00);
            rd_reg(2'b00, r);
            chk("R3 DDRA read", r, 8'(v));
            chk("R9 no stb on DDR read", {7'b0, a_rd_stb}, 8'h00);
        end
        chk("R4 pa_out untouched", pa_out, 8'h00);

        // R3: route to output register
        wr_reg(2'b01, 8'h04);
        chk("R2 a_cfg", {2'b0, a_cfg}, 8'h04);
        wr_reg(2'b00, 8'hA5);
        chk("R4 pa_out", pa_out, 8'hA5);
        chk("R3 pa_oe kept", pa_oe, 8'hFF);
        chk("R10 no stb on A write", {7'b0, b_wr_stb}, 8'h00);

        // R2: side B control and DDRB sweep
        wr_reg(2'b11, 8'h2B);
        chk("R2 b_cfg", {2'b0, b_cfg}, 8'h2B);
        rd_reg(2'b11, r); chk("R2 CRB read", r, 8'h2B);
        rd_reg(2'b01, r); chk("R2 CRA read", r, 8'h04);
        for (int v = 0; v < 256; v++) begin
            wr_reg(2'b10, 8'(v));
            chk("R4 pb_oe", pb_oe, 8'(v));
            chk("R10 no stb on ddrb", {7'b0, b_wr_stb}, 8'h00);
        end

        // R6/R10: port B mixed readback
        for (int d = 0; d < 256; d += 15) begin
            wr_reg(2'b11, 8'h00);
            wr_reg(2'b10, 8'(d));
            wr_reg(2'b11, 8'h04);
            wr_reg(2'b10, 8'h96);
            chk("R10 b_wr_stb", {7'b0, b_wr_stb}, 8'h01);
            chk("R4 pb_out", pb_out, 8'h96);
            pb_in = ~8'(d) ^ 8'h33;
            exp_b = (8'(d) & 8'h96) | (~8'(d) & pb_in);
            rd_reg(2'b10, r);
            chk("R6 port B read", r, exp_b);
            chk("R9 no stb on B read", {7'b0, a_rd_stb}, 8'h00);
        end

        // R5/R9: port A pin readback with all lines as outputs
        for (int v = 0; v < 256; v++) begin
            pa_in = 8'(v);
            rd_reg(2'b00, r);
            chk("R5 port A read", r, 8'(v));
            chk("R9 a_rd_stb", {7'b0, a_rd_stb}, 8'h01);
            @(posedge clk); @(negedge clk);
            chk("R9 a_rd_stb one cycle", {7'b0, a_rd_stb}, 8'h00);
        end

        // R7: commit timing and route taken at commit
        wr_reg(2'b01, 8'h00);
        cs = 1; wr = 1; sel = 2'b01; wdata = 8'h04;
        @(posedge clk); @(negedge clk);
        sel = 2'b00; wdata = 8'h5A;
        @(posedge clk); @(negedge clk);
        cs = 0; wr = 0;
        chk("R7 not yet visible", pa_out, 8'hA5);
        @(posedge clk); @(negedge clk);
        chk("R7 committed to ORA", pa_out, 8'h5A);
        chk("R7 DDRA kept", pa_oe, 8'hFF);

        // R8: flags
        wr_reg(2'b01, 8'h00);
        flag_pulse(2'b11, 2'b00);
        rd_reg(2'b01, r); chk("R8 flags set", r, 8'hC0);
        wr_reg(2'b01, 8'h3B);
        rd_reg(2'b01, r); chk("R8 write keeps flags", r, 8'hFB);
        wr_reg(2'b01, 8'h00);
        rd_reg(2'b01, r); chk("R8 write cannot clear", r, 8'hC0);
        rd_reg(2'b00, r);
        rd_reg(2'b01, r); chk("R8 DDR read keeps", r, 8'hC0);
        wr_reg(2'b01, 8'h04);
        rd_reg(2'b01, r); chk("R8 before clear", r, 8'hC4);
        rd_reg(2'b00, r);
        rd_reg(2'b01, r); chk("R8 data read clears", r, 8'h04);
        cs = 1; rd = 1; sel = 2'b00; a_flag_set = 2'b01;
        @(posedge clk); @(negedge clk);
        cs = 0; rd = 0; a_flag_set = 2'b00;
        rd_reg(2'b01, r); chk("R8 set wins", r, 8'h44);
        flag_pulse(2'b00, 2'b10);
        rd_reg(2'b11, r); chk("R8 B flag", r, 8'h84);
        rd_reg(2'b00, r);
        rd_reg(2'b11, r); chk("R8 A read keeps B", r, 8'h84);
        rd_reg(2'b10, r);
        rd_reg(2'b11, r); chk("R8 B read clears", r, 8'h04);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule